// File: doc/BRIEF.md
# SCSI Host Adapter Bus Glue

This block sits between a 16-bit host expansion bus and an 8-bit SCSI protocol controller that the host drives by programmed I/O. It decodes a 64 KB window: the lower half reads back a 16 KB boot ROM, and the upper half holds one board status/control register plus the controller's pointer-select, auxiliary-status, indexed and direct data ports. The controller is reached through a single-cycle strobe with a port code, so the controller tells a pointer-advancing access apart from a direct data access.

The block latches an interrupt when the controller reports that PIO data is ready and software has enabled it. One bit of the status register holds the controller in reset, through a pulse of fixed length. A 16-bit read in the status region returns the status byte and one controller data byte together, so a polling loop needs only one bus cycle per transferred byte.

Read data comes back on the cycle after the request. A byte access uses host_wdata[7:0] and returns on host_rdata[7:0], with host_rdata[15:8] at zero.

Top module: `scsi_pio_glue`

## Requirements
- R1: A byte read with address bit 15 clear returns the ROM byte at offset o = addr[14:0]. For o < 16384 that byte is o[7:0] XOR {2'b00, o[13:8]}.
- R2: ROM offsets 16384 to 32767 read as 0xFF, in both byte and word reads.
- R3: A word read in ROM space returns the byte at the even offset (addr with bit 0 cleared) in bits 15:8 and the next odd byte in bits 7:0.
- R4: A byte read at a register-space offset r with (r & 0xF1) == 0x80 returns the stored status bits 6:0. Bit 7 carries the live ctl_avail input.
- R5: Register-space byte reads strobe the controller with no write and return ctl_rdata. (r & 0xF1) == 0x81 uses port code 2 (direct data, pointer unchanged). r == 0xC1 uses port code 0 (auxiliary status). r == 0xC3 uses port code 1 (indexed register). A byte write to 0xC1 strobes port 0 (pointer select) and a byte write to 0xC3 strobes port 1, both with ctl_we high and the byte on ctl_wdata. Other offsets read as zero and raise no strobe.
- R6: A byte write with (r & 0xF1) == 0xE1 strobes port code 2 with ctl_we high and the written byte on ctl_wdata.
- R7: A byte write with (r & 0xF0) == 0x80 stores data bits 6:0 in the status register. When data bit 6 is 0, ctl_reset is high for exactly 4 cycles, starting at the clock edge that takes the write.
- R8: While ctl_avail is high and status bit 4 is set, status bit 3 becomes 1 at the next edge and host_irq (status bit 3) goes high. With bit 4 clear, no interrupt is raised.
- R9: Once set, host_irq stays high, even after ctl_avail falls, until a status write clears bit 3 or a reset occurs.
- R10: A word read with (r & 0xF0) == 0x80 returns {status byte as in R4, controller data via port 2} and strobes port 2. Other word reads in register space return 0 and raise no strobe.
- R11: Word writes anywhere, and all writes in ROM space, raise no strobe, leave the status register unchanged and do not pulse ctl_reset.
- R12: A bus reset clears the status register and host_irq, and holds ctl_reset high from reset until a fixed number of cycles after the reset is released.
- R13: host_rvalid is high in the cycle after every read request, and host_rdata is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Single-cycle access request |
| host_we | input | 1 | 1 for a write |
| host_wide | input | 1 | 1 for a 16-bit access, 0 for a byte |
| host_addr | input | 16 | Offset inside the 64 KB window |
| host_wdata | input | 16 | Write data; bytes use bits 7:0 |
| host_rdata | output | 16 | Read data, one cycle after the request |
| host_rvalid | output | 1 | Read data valid |
| host_irq | output | 1 | Latched PIO-ready interrupt |
| ctl_strobe | output | 1 | Controller access strobe |
| ctl_we | output | 1 | Controller access is a write |
| ctl_port | output | 2 | 0 select/aux, 1 indexed, 2 direct data |
| ctl_wdata | output | 8 | Byte to the controller |
| ctl_rdata | input | 8 | Byte from the controller for the strobed port |
| ctl_avail | input | 1 | Controller has PIO data available |
| ctl_reset | output | 1 | Controller reset |

## Verification
A corrupted status register shows on the very next status read, and its interrupt-enable and pending bits show on host_irq one edge later. A stuck or misloaded reset counter shows as a ctl_reset pulse of the wrong length, or a pulse where none belongs, seen within a few cycles of the write. A decode slip shows in the same cycle as a strobe with the wrong port code, a missing strobe or a spurious one, and then one cycle later as wrong read data.

// File: rtl/scsi_glue_pkg.sv
package scsi_glue_pkg;
  localparam int WIN_W  = 16;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 7;

  typedef enum logic [1:0] {
    PORT_AUX    = 2'd0,
    PORT_IDX    = 2'd1,
    PORT_DIRECT = 2'd2
  } ctl_port_e;

  // Generated boot image; an integration replaces this function.
  function automatic logic [BYTE_W-1:0] rom_image(input logic [13:0] off);
    return off[7:0] ^ {2'b00, off[13:8]};
  endfunction
endpackage

// File: rtl/glue_decode.sv
module glue_decode
  import scsi_glue_pkg::*;
(
  input  logic             req,
  input  logic             we,
  input  logic             wide,
  input  logic [WIN_W-1:0] addr,
  output logic             rom_rd,
  output logic             stat_rd,
  output logic             stat_wr,
  output logic             pair_rd,
  output logic             strobe,
  output logic             strobe_we,
  output ctl_port_e        port
);
  logic [WIN_W-2:0] r;
  logic [7:0]       lo;
  logic             m_sr, m_dr, m_sw, m_dw, m_aux, m_idx;

  assign r     = addr[WIN_W-2:0];
  assign lo    = addr[7:0];
  assign m_sr  = (lo & 8'hF1) == 8'h80;
  assign m_dr  = (lo & 8'hF1) == 8'h81;
  assign m_sw  = (lo & 8'hF0) == 8'h80;
  assign m_dw  = (lo & 8'hF1) == 8'hE1;
  assign m_aux = r == 15'h00C1;
  assign m_idx = r == 15'h00C3;

  always_comb begin
    rom_rd    = 1'b0;
    stat_rd   = 1'b0;
    stat_wr   = 1'b0;
    pair_rd   = 1'b0;
    strobe    = 1'b0;
    strobe_we = 1'b0;
    port      = PORT_AUX;
    if (req && !addr[WIN_W-1]) begin
      rom_rd = !we;
    end else if (req) begin
      if (!we && !wide) begin
        if (m_sr) stat_rd = 1'b1;
        else if (m_dr)  begin strobe = 1'b1; port = PORT_DIRECT; end
        else if (m_aux) begin strobe = 1'b1; port = PORT_AUX;    end
        else if (m_idx) begin strobe = 1'b1; port = PORT_IDX;    end
      end else if (!we && wide) begin
        if (m_sw) begin pair_rd = 1'b1; strobe = 1'b1; port = PORT_DIRECT; end
      end else if (we && !wide) begin
        if (m_sw) stat_wr = 1'b1;
        else if (m_dw)  begin strobe = 1'b1; strobe_we = 1'b1; port = PORT_DIRECT; end
        else if (m_aux) begin strobe = 1'b1; strobe_we = 1'b1; port = PORT_AUX;    end
        else if (m_idx) begin strobe = 1'b1; strobe_we = 1'b1; port = PORT_IDX;    end
      end
    end
  end

  // R11: a wide write never reaches the controller or the status register
  always_comb begin
    if (req && we && wide) begin
      assert_no_wide_write_R11: assert (!strobe && !stat_wr);
    end
  end
endmodule

// File: rtl/glue_rom.sv
module glue_rom
  import scsi_glue_pkg::*;
#(
  parameter int ROM_BYTES = 16384
) (
  input  logic [WIN_W-2:0] base,
  output logic [BUS_W-1:0] word_q
);
  localparam int LANES = BUS_W / BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WIN_W-2:0]  off;
    logic [BYTE_W-1:0] val;
    assign off = {base[WIN_W-2:1], g[0]};
    assign val = (32'(off) < ROM_BYTES) ? rom_image(off[13:0]) : 8'hFF;
    // even offset lands in the upper byte
    assign word_q[BUS_W-1-g*BYTE_W -: BYTE_W] = val;
  end
endmodule

// File: rtl/glue_status.sv
module glue_status
  import scsi_glue_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_i_n,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] wdata,
  input  logic              avail,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq,
  output logic              ctl_reset
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam int B_RUN = 6;
  localparam int B_IEN = 4;
  localparam int B_INT = 3;

  logic [STAT_W-1:0] stat_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              stat_en, cnt_en, set_int, load;

  assign set_int = avail && stat_q[B_IEN];
  assign load    = stat_wr && !wdata[B_RUN];
  assign stat_en = stat_wr || set_int;
  assign cnt_en  = load || (cnt_q != '0);

  always_comb begin
    stat_d = stat_q;
    if (stat_wr)      stat_d = wdata;
    else if (set_int) stat_d[B_INT] = 1'b1;
    cnt_d = load ? CNT_W'(RST_CYCLES) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      stat_q <= '0;
      cnt_q  <= CNT_W'(RST_CYCLES);
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  assign irq       = stat_q[B_INT];
  assign ctl_reset = cnt_q != '0;

  assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (stat_wr && !wdata[B_RUN]) |=> ctl_reset);
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (avail && stat_q[B_IEN] && !stat_wr) |=> irq);
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq && !stat_wr) |=> irq);
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(irq) |-> ($past(avail && stat_q[B_IEN]) || $past(stat_wr && wdata[B_INT])));
endmodule

// File: rtl/scsi_pio_glue.sv
module scsi_pio_glue
  import scsi_glue_pkg::*;
#(
  parameter int ROM_BYTES  = 16384,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic              host_wide,
  input  logic [WIN_W-1:0]  host_addr,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  output logic              host_rvalid,
  output logic              host_irq,
  output logic              ctl_strobe,
  output logic              ctl_we,
  output logic [1:0]        ctl_port,
  output logic [BYTE_W-1:0] ctl_wdata,
  input  logic [BYTE_W-1:0] ctl_rdata,
  input  logic              ctl_avail,
  output logic              ctl_reset
);
  logic [1:0]        sync_q;
  logic              rst_i_n;
  logic              rom_rd, stat_rd, stat_wr, pair_rd, rd;
  ctl_port_e         port;
  logic [BUS_W-1:0]  rom_word, rd_d, rdata_q;
  logic [STAT_W-1:0] stat_q;
  logic [BYTE_W-1:0] stat_byte;
  logic              rvalid_q;
  logic              unused_hi;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i_n = sync_q[1];

  glue_decode i_dec (
    .req(host_req), .we(host_we), .wide(host_wide), .addr(host_addr),
    .rom_rd(rom_rd), .stat_rd(stat_rd), .stat_wr(stat_wr), .pair_rd(pair_rd),
    .strobe(ctl_strobe), .strobe_we(ctl_we), .port(port)
  );

  glue_rom #(.ROM_BYTES(ROM_BYTES)) i_rom (
    .base(host_addr[WIN_W-2:0]), .word_q(rom_word)
  );

  glue_status #(.RST_CYCLES(RST_CYCLES)) i_stat (
    .clk(clk), .rst_i_n(rst_i_n), .stat_wr(stat_wr),
    .wdata(host_wdata[STAT_W-1:0]), .avail(ctl_avail),
    .stat_q(stat_q), .irq(host_irq), .ctl_reset(ctl_reset)
  );

  assign ctl_port  = port;
  assign ctl_wdata = host_wdata[BYTE_W-1:0];
  assign unused_hi = ^host_wdata[BUS_W-1:BYTE_W];
  assign stat_byte = {ctl_avail, stat_q};
  assign rd        = host_req && !host_we;

  always_comb begin
    rd_d = '0;
    if (rom_rd) begin
      if (host_wide)         rd_d = rom_word;
      else if (host_addr[0]) rd_d = {8'h00, rom_word[7:0]};
      else                   rd_d = {8'h00, rom_word[15:8]};
    end else if (stat_rd) begin
      rd_d = {8'h00, stat_byte};
    end else if (pair_rd) begin
      rd_d = {stat_byte, ctl_rdata};
    end else if (ctl_strobe && !ctl_we) begin
      rd_d = {8'h00, ctl_rdata};
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;

  assert_strobe_regspace_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    ctl_strobe |-> (host_req && host_addr[WIN_W-1]));
  assert_rvalid_follows_R13: assert property (@(posedge clk) disable iff (!rst_i_n)
    (host_req && !host_we) |=> host_rvalid);
  assert_no_spurious_valid_R13: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(host_req && !host_we) |=> !host_rvalid);
endmodule

// File: tb/test_scsi_pio_glue.sv
`timescale 1ns/1ps
module test_scsi_pio_glue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0, host_wide = 1'b0;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic [15:0] host_rdata;
  logic host_rvalid, host_irq, ctl_strobe, ctl_we, ctl_reset;
  logic [1:0] ctl_port;
  logic [7:0] ctl_wdata, ctl_rdata;
  logic ctl_avail = 1'b0;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic s_stb, s_we; logic [1:0] s_port; logic [7:0] s_wd;

  always #2.5 clk = ~clk;

  // controller model: fixed byte per port
  assign ctl_rdata = (ctl_port == 2'd0) ? 8'h3C : (ctl_port == 2'd1) ? 8'h5A : 8'hC7;

  scsi_pio_glue i_scsi_pio_glue (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_irq(host_irq),
    .ctl_strobe(ctl_strobe), .ctl_we(ctl_we), .ctl_port(ctl_port),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_avail(ctl_avail),
    .ctl_reset(ctl_reset)
  );

  typedef struct packed {
    logic we; logic wide; logic [15:0] addr; logic [15:0] wd; logic [15:0] exp;
    logic stb; logic [1:0] port; logic cwe; logic [7:0] cwd; logic [7:0] tag;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,16'h0000,16'h0000,16'h0000,1'b0,2'd0,1'b0,8'h00,8'd1},  // R1
    '{1'b0,1'b0,16'h1234,16'h0000,16'h0026,1'b0,2'd0,1'b0,8'h00,8'd1},  // R1
    '{1'b0,1'b0,16'h3FFF,16'h0000,16'h00C0,1'b0,2'd0,1'b0,8'h00,8'd1},  // R1
    '{1'b0,1'b0,16'h4000,16'h0000,16'h00FF,1'b0,2'd0,1'b0,8'h00,8'd2},  // R2
    '{1'b0,1'b0,16'h7FFE,16'h0000,16'h00FF,1'b0,2'd0,1'b0,8'h00,8'd2},  // R2
    '{1'b0,1'b1,16'h0102,16'h0000,16'h0302,1'b0,2'd0,1'b0,8'h00,8'd3},  // R3
    '{1'b0,1'b1,16'h3FFF,16'h0000,16'hC1C0,1'b0,2'd0,1'b0,8'h00,8'd3},  // R3
    '{1'b0,1'b1,16'h5000,16'h0000,16'hFFFF,1'b0,2'd0,1'b0,8'h00,8'd2},  // R2
    '{1'b1,1'b0,16'h0010,16'h00AB,16'h0000,1'b0,2'd0,1'b0,8'h00,8'd11}, // R11
    '{1'b0,1'b0,16'h80C1,16'h0000,16'h003C,1'b1,2'd0,1'b0,8'h00,8'd5},  // R5
    '{1'b0,1'b0,16'h80C3,16'h0000,16'h005A,1'b1,2'd1,1'b0,8'h00,8'd5},  // R5
    '{1'b0,1'b0,16'h8081,16'h0000,16'h00C7,1'b1,2'd2,1'b0,8'h00,8'd5},  // R5
    '{1'b0,1'b0,16'h8181,16'h0000,16'h00C7,1'b1,2'd2,1'b0,8'h00,8'd5},  // R5
    '{1'b0,1'b0,16'h80C5,16'h0000,16'h0000,1'b0,2'd0,1'b0,8'h00,8'd5},  // R5
    '{1'b1,1'b0,16'h80C1,16'h0007,16'h0000,1'b1,2'd0,1'b1,8'h07,8'd5},  // R5
    '{1'b1,1'b0,16'h80C3,16'h0099,16'h0000,1'b1,2'd1,1'b1,8'h99,8'd5},  // R5
    '{1'b1,1'b0,16'h80E1,16'h0042,16'h0000,1'b1,2'd2,1'b1,8'h42,8'd6},  // R6
    '{1'b1,1'b0,16'h80E3,16'h00E4,16'h0000,1'b1,2'd2,1'b1,8'hE4,8'd6},  // R6
    '{1'b1,1'b0,16'h80E0,16'h0011,16'h0000,1'b0,2'd0,1'b0,8'h00,8'd6},  // R6
    '{1'b1,1'b1,16'h80C1,16'h1234,16'h0000,1'b0,2'd0,1'b0,8'h00,8'd11}, // R11
    '{1'b1,1'b1,16'h8080,16'h0000,16'h0000,1'b0,2'd0,1'b0,8'h00,8'd11}, // R11
    '{1'b0,1'b1,16'h80C1,16'h0000,16'h0000,1'b0,2'd0,1'b0,8'h00,8'd10}, // R10
    '{1'b0,1'b1,16'h808E,16'h0000,16'h00C7,1'b1,2'd2,1'b0,8'h00,8'd10}, // R10
    '{1'b0,1'b0,16'h8080,16'h0000,16'h0000,1'b0,2'd0,1'b0,8'h00,8'd4}   // R4
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, capture strobes, return at the next falling edge
  task automatic access(input logic we, input logic wide, input logic [15:0] a,
                        input logic [15:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_wide = wide; host_addr = a; host_wdata = d;
    #1;
    s_stb = ctl_strobe; s_we = ctl_we; s_port = ctl_port; s_wd = ctl_wdata;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0; host_wide = 1'b0;
  endtask

  task automatic read_stat(input string req, input logic [7:0] exp);
    access(1'b0, 1'b0, 16'h8080, 16'h0000);
    check(req, host_rdata, {8'h00, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int highs;
    // R12: reset state
    repeat (3) @(negedge clk);
    check("R12 irq in reset", {15'd0, host_irq}, 16'd0);
    check("R12 ctl_reset in reset", {15'd0, ctl_reset}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 ctl_reset after release", {15'd0, ctl_reset}, 16'd1);
    repeat (10) @(negedge clk);
    check("R12 ctl_reset settles", {15'd0, ctl_reset}, 16'd0);
    read_stat("R12 status zero", 8'h00);
    check("R13 rvalid", {15'd0, host_rvalid}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      string tg = $sformatf("R%0d vec%0d", v.tag, i);
      access(v.we, v.wide, v.addr, v.wd);
      check({tg, " strobe"}, {15'd0, s_stb}, {15'd0, v.stb});
      if (v.stb) begin
        check({tg, " port"}, {14'd0, s_port}, {14'd0, v.port});
        check({tg, " ctl_we"}, {15'd0, s_we}, {15'd0, v.cwe});
        if (v.cwe) check({tg, " ctl_wdata"}, {8'd0, s_wd}, {8'd0, v.cwd});
      end
      check({tg, " rvalid R13"}, {15'd0, host_rvalid}, {15'd0, !v.we});
      if (!v.we) check({tg, " rdata"}, host_rdata, v.exp);
    end
    // R11: word writes left status and controller reset untouched
    check("R11 no reset pulse", {15'd0, ctl_reset}, 16'd0);
    read_stat("R11 status kept", 8'h00);

    // R7: bit 6 clear gives a 4-cycle controller reset
    access(1'b1, 1'b0, 16'h8080, 16'h00B5);
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      if (ctl_reset) highs++;
      @(negedge clk);
    end
    check("R7 reset length", 16'(highs), 16'd4);
    read_stat("R7 low 7 bits stored", 8'h35);
    access(1'b1, 1'b0, 16'h808C, 16'h0050);
    check("R7 bit6 set no reset", {15'd0, ctl_reset}, 16'd0);
    check("R8 no irq without data", {15'd0, host_irq}, 16'd0);

    // R8 / R4 / R10
    ctl_avail = 1'b1;
    @(negedge clk);
    check("R8 irq raised", {15'd0, host_irq}, 16'd1);
    read_stat("R4 live avail bit", 8'hD8);
    access(1'b0, 1'b1, 16'h8080, 16'h0000);
    check("R10 status+data word", host_rdata, 16'hD8C7);

    // R9: hold after data goes away, clear by write
    ctl_avail = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 irq held", {15'd0, host_irq}, 16'd1);
    read_stat("R9 pending bit", 8'h58);
    access(1'b1, 1'b0, 16'h8080, 16'h0050);
    check("R9 irq cleared", {15'd0, host_irq}, 16'd0);

    // R8: enable clear blocks the interrupt
    access(1'b1, 1'b0, 16'h8080, 16'h0040);
    ctl_avail = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 disabled no irq", {15'd0, host_irq}, 16'd0);
    read_stat("R8 status disabled", 8'hC0);
    ctl_avail = 1'b0;

    // R12: reset mid-run clears a pending interrupt
    access(1'b1, 1'b0, 16'h8080, 16'h0048);
    check("R9 software-set irq", {15'd0, host_irq}, 16'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R12 irq cleared by reset", {15'd0, host_irq}, 16'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    read_stat("R12 status after reset", 8'h00);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule